// File: doc/BRIEF.md
# Port Function Control Register

This block holds one byte that decides, pin by pin, whether an 8-bit general-purpose port acts as plain I/O or carries a bus-control or status signal: the read/write strobe, the low-byte strobe, the external bus clock, two instruction-queue status lines, or a clock test output. Software writes the byte through a simple write strobe and reads it back combinationally at any time.

Write permission depends on the operating mode. It is tracked by a small lock state machine with three named states. `LK_FRESH` holds from reset until the first write. From there, a write in a normal mode applies the data and moves to `LK_SHUT` (transition FRESH→SHUT), where every later write is dropped. A write in a special mode is discarded and moves to `LK_OPEN` (transition FRESH→OPEN), where every later write is applied. `LK_OPEN` and `LK_SHUT` only loop on themselves until reset. The clock-disable bit has its own rule on top of this. It is pinned to 0 while the bus is expanded. In special single-chip mode it accepts every write, including the first.

A pin multiplexer then combines the byte with the mode inputs. For each pin it produces an output enable, an output value and an alternate-function flag. Pins left as general-purpose I/O take their direction and data from the port's own direction and data inputs.

Top module: `pfc_port_ctrl`

## Requirements
- R1: After reset the byte is 0, except in special modes with an expanded bus, where bit 0 (read/write enable) and bit 1 (low-strobe enable) reset to 1. The bit layout is: bit 0 read/write enable, bit 1 low-strobe enable, bit 2 clock disable, bit 3 pipe-status enable, bit 4 clock-test enable.
- R2: In normal modes the first write after reset loads bits 0, 1, 3 and 4 together, in one cycle. Every later write leaves the byte unchanged.
- R3: In special modes the first write after reset leaves bits 0, 1, 3 and 4 unchanged. Every later write loads them.
- R4: `rd_data` shows the current byte in every cycle and every mode. Bits 7 to 5 always read 0.
- R5: The clock-disable bit reads 0 and ignores writes while `mode_bus` is non-zero (expanded). In normal single-chip mode it follows the R2 rule. In special single-chip mode it is loaded by every write, including the first.
- R6: Pin 2 is an output driving `bus_rw` only when the bus is expanded and bit 0 is 1. Otherwise it is general-purpose I/O.
- R7: Pin 3 is an output driving `bus_lstrb` only when bit 1 is 1 and the mode is expanded and is not normal expanded narrow (`mode_bus`=01). Otherwise it is general-purpose I/O.
- R8: Pin 4 drives `eclk_in` whenever the bus is expanded. In single-chip mode it drives `eclk_in` only when bit 2 is 0 and either `ivis` is 1 or `estr` is 0. Otherwise it is general-purpose I/O.
- R9: With bit 3 set, pin 5 drives `pipe_st[0]` and pin 6 drives `pipe_st[1]`, whatever bit 4 holds.
- R10: With bit 3 clear, pin 6 drives `clk_test` only when bit 4 is 1 in special expanded modes. Otherwise it is general-purpose I/O.
- R11: A pin in general-purpose mode has `pin_alt`=0, `pin_oe`=`gp_dir` and `pin_out`=`gp_out`. Pins 0, 1 and 7 are always general-purpose. An alternate pin has `pin_alt`=1 and `pin_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| mode_bus | input | 2 | 00 single-chip, 01 expanded narrow, 10/11 expanded wide |
| wr_en | input | 1 | Write strobe for the whole byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| ivis | input | 1 | Internal visibility enable |
| estr | input | 1 | Clock stretch enable |
| gp_dir | input | 8 | General-purpose direction per pin (1 = output) |
| gp_out | input | 8 | General-purpose output data |
| bus_rw | input | 1 | Read/write strobe source |
| bus_lstrb | input | 1 | Low-byte strobe source |
| eclk_in | input | 1 | Bus clock source |
| pipe_st | input | 2 | Instruction-queue status source |
| clk_test | input | 1 | Clock test signal source |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_alt | output | 8 | Per-pin alternate-function flag |

## Verification
The assertions assume that `mode_special` and `mode_bus` stay fixed between resets and that no write arrives while reset is active. The lock rules and the write-acceptance properties only make sense under those conditions. The bench therefore changes the mode only while reset is held, and starts writing a few cycles after release. Outside reset it randomises writes, write data and every pin-function input on each cycle, so the mode-specific write rules and the mux priorities are exercised together.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    // register bit positions (the pin mux decodes them)
    localparam int BIT_RW       = 0;
    localparam int BIT_LSTRB    = 1;
    localparam int BIT_ECLK_OFF = 2;
    localparam int BIT_PIPE     = 3;
    localparam int BIT_CTEST    = 4;

    // pin positions carrying alternate functions
    localparam int PIN_RW    = 2;
    localparam int PIN_LSTRB = 3;
    localparam int PIN_ECLK  = 4;
    localparam int PIN_PIPE0 = 5;
    localparam int PIN_PIPE1 = 6;

    typedef enum logic [1:0] {
        LK_FRESH = 2'd0,
        LK_OPEN  = 2'd1,
        LK_SHUT  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/pfc_lock_fsm.sv
module pfc_lock_fsm
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic mode_special,
    output logic gen_accept
);
    lock_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_FRESH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LK_FRESH: if (wr_en) state_nx = mode_special ? LK_OPEN : LK_SHUT;
            LK_OPEN:  state_nx = LK_OPEN;
            LK_SHUT:  state_nx = LK_SHUT;
            default:  state_nx = LK_FRESH;
        endcase
    end

    always_comb begin
        gen_accept = 1'b0;
        unique case (state)
            LK_FRESH: gen_accept = wr_en && !mode_special;
            LK_OPEN:  gen_accept = wr_en;
            LK_SHUT:  gen_accept = 1'b0;
            default:  gen_accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfc_ctrl_reg.sv
module pfc_ctrl_reg
    import pfc_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_accept,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             mode_special,
    input  logic             is_expanded,
    output logic [REG_W-1:0] ctrl
);
    logic [REG_W-1:0] rst_val;
    logic             eclk_accept;

    always_comb begin
        rst_val            = '0;
        rst_val[BIT_RW]    = mode_special && is_expanded;
        rst_val[BIT_LSTRB] = mode_special && is_expanded;
    end

    // clock-disable bit: pinned in expanded, free in special single-chip
    assign eclk_accept = !is_expanded && (mode_special ? wr_en : gen_accept);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b == BIT_ECLK_OFF) begin : g_eclk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           ctrl[b] <= 1'b0;
                else if (is_expanded) ctrl[b] <= 1'b0;
                else if (eclk_accept) ctrl[b] <= wr_data[b];
            end
        end else if (b == BIT_RW || b == BIT_LSTRB || b == BIT_PIPE || b == BIT_CTEST) begin : g_gen
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          ctrl[b] <= rst_val[b];
                else if (gen_accept) ctrl[b] <= wr_data[b];
            end
        end else begin : g_rsv
            assign ctrl[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pfc_pin_mux.sv
module pfc_pin_mux
    import pfc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int REG_W  = 8
) (
    input  logic [REG_W-1:0]  ctrl,
    input  logic              mode_special,
    input  logic              is_expanded,
    input  logic              is_narrow,
    input  logic              ivis,
    input  logic              estr,
    input  logic [PORT_W-1:0] gp_dir,
    input  logic [PORT_W-1:0] gp_out,
    input  logic              bus_rw,
    input  logic              bus_lstrb,
    input  logic              eclk_in,
    input  logic [1:0]        pipe_st,
    input  logic              clk_test,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_alt
);
    logic [PORT_W-1:0] alt_sel;
    logic [PORT_W-1:0] alt_val;

    always_comb begin
        alt_sel = '0;
        alt_val = '0;
        // read/write strobe
        alt_sel[PIN_RW]    = is_expanded && ctrl[BIT_RW];
        alt_val[PIN_RW]    = bus_rw;
        // low-byte strobe, unused on a normal narrow bus
        alt_sel[PIN_LSTRB] = is_expanded && ctrl[BIT_LSTRB] && !(!mode_special && is_narrow);
        alt_val[PIN_LSTRB] = bus_lstrb;
        // bus clock
        alt_sel[PIN_ECLK]  = is_expanded || (!ctrl[BIT_ECLK_OFF] && (ivis || !estr));
        alt_val[PIN_ECLK]  = eclk_in;
        // queue status, pipe overrides clock test on the shared pin
        alt_sel[PIN_PIPE0] = ctrl[BIT_PIPE];
        alt_val[PIN_PIPE0] = pipe_st[0];
        if (ctrl[BIT_PIPE]) begin
            alt_sel[PIN_PIPE1] = 1'b1;
            alt_val[PIN_PIPE1] = pipe_st[1];
        end else begin
            alt_sel[PIN_PIPE1] = ctrl[BIT_CTEST] && mode_special && is_expanded;
            alt_val[PIN_PIPE1] = clk_test;
        end
    end

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        assign pin_alt[p] = alt_sel[p];
        assign pin_oe[p]  = alt_sel[p] ? 1'b1       : gp_dir[p];
        assign pin_out[p] = alt_sel[p] ? alt_val[p] : gp_out[p];
    end
endmodule

// File: rtl/pfc_port_ctrl.sv
module pfc_port_ctrl #(
    parameter int PORT_W = 8,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_special,
    input  logic [1:0]        mode_bus,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ivis,
    input  logic              estr,
    input  logic [PORT_W-1:0] gp_dir,
    input  logic [PORT_W-1:0] gp_out,
    input  logic              bus_rw,
    input  logic              bus_lstrb,
    input  logic              eclk_in,
    input  logic [1:0]        pipe_st,
    input  logic              clk_test,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_alt
);
    logic             is_expanded;
    logic             is_narrow;
    logic             gen_accept;
    logic [REG_W-1:0] ctrl;

    assign is_expanded = (mode_bus != 2'b00);
    assign is_narrow   = (mode_bus == 2'b01);

    pfc_lock_fsm u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .mode_special (mode_special),
        .gen_accept   (gen_accept)
    );

    pfc_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_accept   (gen_accept),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .mode_special (mode_special),
        .is_expanded  (is_expanded),
        .ctrl         (ctrl)
    );

    pfc_pin_mux #(.PORT_W(PORT_W), .REG_W(REG_W)) u_mux (
        .ctrl         (ctrl),
        .mode_special (mode_special),
        .is_expanded  (is_expanded),
        .is_narrow    (is_narrow),
        .ivis         (ivis),
        .estr         (estr),
        .gp_dir       (gp_dir),
        .gp_out       (gp_out),
        .bus_rw       (bus_rw),
        .bus_lstrb    (bus_lstrb),
        .eclk_in      (eclk_in),
        .pipe_st      (pipe_st),
        .clk_test     (clk_test),
        .pin_oe       (pin_oe),
        .pin_out      (pin_out),
        .pin_alt      (pin_alt)
    );

    assign rd_data = ctrl;
endmodule

// File: rtl/pfc_port_ctrl_chk.sv
module pfc_port_ctrl_chk #(
    parameter int PORT_W = 8,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_special,
    input logic [1:0]        mode_bus,
    input logic              wr_en,
    input logic [REG_W-1:0]  rd_data,
    input logic [PORT_W-1:0] gp_dir,
    input logic [PORT_W-1:0] gp_out,
    input logic [1:0]        pipe_st,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_alt
);
    logic seen_wr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seen_wr <= 1'b0;
        else if (wr_en) seen_wr <= 1'b1;
    end

    assert_locked_after_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_special && seen_wr) |=> $stable(rd_data));

    assert_special_first_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_special && !seen_wr && wr_en && mode_bus != 2'b00) |=> $stable(rd_data));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:5] == '0);

    assert_clkoff_pinned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bus != 2'b00) |-> !rd_data[2]);

    assert_rw_single_chip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bus == 2'b00) |-> !pin_alt[2]);

    assert_pipe_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> (pin_alt[5] && pin_alt[6] && pin_out[6] == pipe_st[1] && pin_out[5] == pipe_st[0]));

    assert_gpio_pin0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_alt[0] && pin_oe[0] == gp_dir[0] && pin_out[0] == gp_out[0]);
endmodule

bind pfc_port_ctrl pfc_port_ctrl_chk #(.PORT_W(PORT_W), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_special (mode_special),
    .mode_bus     (mode_bus),
    .wr_en        (wr_en),
    .rd_data      (rd_data),
    .gp_dir       (gp_dir),
    .gp_out       (gp_out),
    .pipe_st      (pipe_st),
    .pin_oe       (pin_oe),
    .pin_out      (pin_out),
    .pin_alt      (pin_alt)
);

// File: tb/test_pfc_port_ctrl.sv
`timescale 1ns/1ps
module test_pfc_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_special = 1'b0;
    logic [1:0] mode_bus = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ivis = 1'b0, estr = 1'b0;
    logic [7:0] gp_dir = 8'h00, gp_out = 8'h00;
    logic       bus_rw = 1'b0, bus_lstrb = 1'b0, eclk_in = 1'b0, clk_test = 1'b0;
    logic [1:0] pipe_st = 2'b00;
    logic [7:0] pin_oe, pin_out, pin_alt;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pfc_port_ctrl i_pfc_port_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .mode_bus(mode_bus),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ivis(ivis), .estr(estr),
        .gp_dir(gp_dir), .gp_out(gp_out), .bus_rw(bus_rw), .bus_lstrb(bus_lstrb),
        .eclk_in(eclk_in), .pipe_st(pipe_st), .clk_test(clk_test),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_alt(pin_alt)
    );

    // ---------------- reference model ----------------
    bit [4:0] m_reg;
    bit       m_seen;
    bit       m_written;  // any accepted change since reset, for tag choice

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg     = 5'b0;
            m_seen    = 0;
            m_written = 0;
            if (mode_special && mode_bus != 0) m_reg = 5'b00011;
        end else begin
            cyc++;
            if (wr_en) begin
                bit expd;
                expd = (mode_bus != 0);
                if (!m_seen) begin
                    if (!mode_special) m_reg = wr_data[4:0];
                    else if (!expd)    m_reg[2] = wr_data[2];
                end else if (mode_special) begin
                    m_reg = wr_data[4:0];
                end
                if (expd) m_reg[2] = 0;
                m_seen    = 1;
                m_written = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic check_pin(input int p, input string tag, input bit alt, input bit val);
        bit e_oe, e_out;
        e_oe  = alt ? 1'b1 : gp_dir[p];
        e_out = alt ? val  : gp_out[p];
        chk(tag, {5'b0, pin_alt[p], pin_oe[p], pin_out[p]}, {5'b0, alt, e_oe, e_out});
    endtask

    task automatic check_all();
        bit expd, narrow;
        string rtag;
        expd   = (mode_bus != 0);
        narrow = (mode_bus == 2'b01);
        rtag   = !m_written ? "R1" : (mode_special ? "R3" : "R2");
        chk(rtag, {4'b0, rd_data[4], rd_data[3], rd_data[1], rd_data[0]},
                  {4'b0, m_reg[4], m_reg[3], m_reg[1], m_reg[0]});
        chk(m_written ? "R5" : "R1", {7'b0, rd_data[2]}, {7'b0, m_reg[2]});
        chk("R4", {5'b0, rd_data[7:5]}, 8'h00);
        check_pin(2, "R6", expd && m_reg[0], bus_rw);
        check_pin(3, "R7", expd && m_reg[1] && !(narrow && !mode_special), bus_lstrb);
        check_pin(4, "R8", expd ? 1'b1 : (!m_reg[2] && (ivis || !estr)), eclk_in);
        check_pin(5, "R9", m_reg[3], pipe_st[0]);
        if (m_reg[3]) check_pin(6, "R9", 1'b1, pipe_st[1]);
        else          check_pin(6, "R10", m_reg[4] && mode_special && expd, clk_test);
        check_pin(0, "R11", 1'b0, 1'b0);
        check_pin(1, "R11", 1'b0, 1'b0);
        check_pin(7, "R11", 1'b0, 1'b0);
    endtask

    task automatic randomize_pins();
        ivis = 1'($urandom); estr = 1'($urandom);
        gp_dir = 8'($urandom); gp_out = 8'($urandom);
        bus_rw = 1'($urandom); bus_lstrb = 1'($urandom);
        eclk_in = 1'($urandom); clk_test = 1'($urandom);
        pipe_st = 2'($urandom);
    endtask

    initial begin
        for (int md = 0; md < 6; md++) begin
            @(negedge clk);
            rst_n = 1'b0;
            wr_en = 1'b0;
            mode_special = (md >= 3);
            mode_bus = 2'(md % 3);
            @(negedge clk);
            rst_n = 1'b1;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                check_all();
                randomize_pins();
                if (c < 3) begin
                    wr_en = 1'b0;
                end else if (c == 3) begin
                    wr_en = 1'b1;
                    wr_data = 8'hFF;        // first write: all bits set
                end else begin
                    wr_en = ($urandom % 3) == 0;
                    wr_data = 8'($urandom);
                end
            end
        end
        @(negedge clk);
        check_all();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule